// File: doc/BRIEF.md
# Scanline-Stepped Interrupt Timer

This block is an interrupt timer for a game cartridge controller. Software loads a 16-bit count with two byte-wide writes. It then sets a run bit in a control byte. From then on, every horizontal-sync strobe removes a fixed amount of time from the count. The default amount is 113, which is roughly the number of CPU cycles in one scanline. The count therefore tracks CPU cycles with scanline resolution. When the remaining count is no larger than one step, the counter is clamped to zero and a level interrupt request is raised towards the CPU.

The request stays high until software writes the control byte again, or until reset. The count never wraps below zero. If hsync strobes keep arriving while the run bit is set and the count sits at zero, each one raises the request again. Register writes that share a clock with an hsync strobe are resolved in favour of the write.

Top module: `scl_irq_timer`

## Requirements
- R1: A write to address 0xF000 loads count bits [7:0] from the data byte and keeps bits [15:8].
- R2: A write to address 0xF004 loads count bits [15:8] from the data byte and keeps bits [7:0].
- R3: The count changes on an hsync strobe only while bit 1 of the control byte is 1. Control bits other than bit 1 have no effect on counting. Without an hsync strobe or a count write, the count holds.
- R4: A write to address 0xF008 stores the whole data byte as the control byte and drives irq low on the following cycle.
- R5: Each clock cycle with hsync high counts as one strobe. While running, a strobe that finds the count above STEP (default 113) subtracts STEP. A strobe that finds the count at or below STEP sets the count to 0 and drives irq high on the following cycle.
- R6: irq rises only after a running hsync strobe that finds the count at or below STEP. Enabling the run bit alone never raises it.
- R7: Once high, irq stays high until a write to 0xF008 or reset. Count writes do not clear it. A running strobe that finds the count at 0 raises irq again.
- R8: A synchronous active-high reset clears the count, the control byte and irq.
- R9: If a write and an hsync strobe share a clock, the written count byte takes the write data and the other byte takes the strobe's result. The strobe uses the control byte from before the write. A control write in the same clock as a firing strobe leaves irq low.
- R10: Writes to any address other than the three above change neither the count, the control byte nor irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU register write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| hsync | input | 1 | Horizontal-sync strobe, one cycle per scanline |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that hsync and wr_en are single-cycle strobes sampled once per clock. They also assume that each address selects at most one register, so a single cycle never loads a count byte and the control byte together. The bench drives every write and every strobe for exactly one cycle on the falling edge. It applies an hsync together with a write only in the deliberate collision cases. The address values it uses are either exact register addresses or addresses outside the decoded set.

// File: rtl/scl_irq_pkg.sv
`timescale 1ns/1ps
package scl_irq_pkg;

    // What one clock does to the count
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_SUB  = 2'd1,
        STEP_FIRE = 2'd2
    } step_e;

    // Request-line events produced each clock
    typedef struct packed {
        logic set;
        logic clr;
    } irq_evt_t;

    function automatic step_e classify_step(input logic strobe_live,
                                            input logic at_or_below);
        if (!strobe_live)
            return STEP_HOLD;
        else if (at_or_below)
            return STEP_FIRE;
        else
            return STEP_SUB;
    endfunction

    function automatic irq_evt_t make_evt(input step_e outcome,
                                          input logic  ctl_write);
        irq_evt_t e;
        e.clr = ctl_write;
        e.set = (outcome == STEP_FIRE) && !ctl_write;
        return e;
    endfunction

endpackage

// File: rtl/scl_irq_decode.sv
`timescale 1ns/1ps
module scl_irq_decode #(
    parameter int ADDR_W     = 16,
    parameter int NBYTES     = 2,
    parameter int BASE_ADDR  = 'hF000,
    parameter int REG_STRIDE = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NBYTES-1:0] lane_we,
    output logic              ctl_we
);
    localparam int CTL_ADDR = BASE_ADDR + NBYTES * REG_STRIDE;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        localparam int LANE_ADDR = BASE_ADDR + g * REG_STRIDE;
        assign lane_we[g] = wr_en && (wr_addr == ADDR_W'(LANE_ADDR));
    end

    assign ctl_we = wr_en && (wr_addr == ADDR_W'(CTL_ADDR));
endmodule

// File: rtl/scl_irq_count.sv
`timescale 1ns/1ps
module scl_irq_count
    import scl_irq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int STEP   = 113,
    parameter int NBYTES = CNT_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              hsync,
    input  logic [NBYTES-1:0] lane_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_q,
    output step_e             outcome
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] cnt_d;

    assign outcome = classify_step(hsync && run, cnt_q <= STEP_V);

    always_comb begin
        case (outcome)
            STEP_FIRE: stepped = '0;
            STEP_SUB:  stepped = cnt_q - STEP_V;
            default:   stepped = cnt_q;
        endcase
    end

    // a written byte overrides the strobe result for that byte only
    for (genvar g = 0; g < NBYTES; g++) begin : g_merge
        assign cnt_d[g*DATA_W +: DATA_W] =
            lane_we[g] ? wr_data : stepped[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/scl_irq_ctrl.sv
`timescale 1ns/1ps
module scl_irq_ctrl
    import scl_irq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RUN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] wr_data,
    input  step_e             outcome,
    output logic [DATA_W-1:0] ctl_q,
    output logic              run,
    output logic              irq
);
    irq_evt_t evt;

    assign evt = make_evt(outcome, ctl_we);
    assign run = ctl_q[RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            irq   <= 1'b0;
        end else begin
            if (ctl_we)
                ctl_q <= wr_data;
            if (evt.clr)
                irq <= 1'b0;
            else if (evt.set)
                irq <= 1'b1;
        end
    end
endmodule

// File: rtl/scl_irq_timer.sv
`timescale 1ns/1ps
module scl_irq_timer
    import scl_irq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    parameter int STEP       = 113,
    parameter int BASE_ADDR  = 'hF000,
    parameter int REG_STRIDE = 4,
    parameter int RUN_BIT    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hsync,
    output logic              irq
);
    localparam int NBYTES = CNT_W / DATA_W;

    logic [NBYTES-1:0] lane_we;
    logic              ctl_we;
    logic              run;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] ctl_q;
    step_e             outcome;

    scl_irq_decode #(
        .ADDR_W(ADDR_W), .NBYTES(NBYTES),
        .BASE_ADDR(BASE_ADDR), .REG_STRIDE(REG_STRIDE)
    ) decode_i (
        .wr_en(wr_en), .wr_addr(wr_addr),
        .lane_we(lane_we), .ctl_we(ctl_we)
    );

    scl_irq_count #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .STEP(STEP), .NBYTES(NBYTES)
    ) count_i (
        .clk(clk), .rst(rst), .run(run), .hsync(hsync),
        .lane_we(lane_we), .wr_data(wr_data),
        .cnt_q(cnt_q), .outcome(outcome)
    );

    scl_irq_ctrl #(
        .DATA_W(DATA_W), .RUN_BIT(RUN_BIT)
    ) ctrl_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .wr_data(wr_data),
        .outcome(outcome), .ctl_q(ctl_q), .run(run), .irq(irq)
    );
endmodule

// File: rtl/scl_irq_checker.sv
`timescale 1ns/1ps
module scl_irq_checker #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int NBYTES = 2,
    parameter int STEP   = 113
) (
    input logic              clk,
    input logic              rst,
    input logic              hsync,
    input logic              run,
    input logic [NBYTES-1:0] lane_we,
    input logic              ctl_we,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DATA_W-1:0] ctl_q,
    input logic              irq
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    AST_CTL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> ctl_q == $past(wr_data)); // R4

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> !irq); // R4

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(hsync && run) && lane_we == '0) |=> $stable(cnt_q)); // R3

    AST_CNT_SUB: assert property (@(posedge clk) disable iff (rst)
        (hsync && run && cnt_q > STEP_V && lane_we == '0)
        |=> cnt_q == $past(cnt_q) - STEP_V); // R5

    AST_CNT_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (hsync && run && cnt_q <= STEP_V && lane_we == '0)
        |=> cnt_q == '0); // R5

    AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (rst)
        (hsync && run && cnt_q <= STEP_V && !ctl_we) |=> irq); // R5

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(hsync && run)); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctl_we) |=> irq); // R7
endmodule

bind scl_irq_timer scl_irq_checker #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NBYTES(NBYTES), .STEP(STEP)
) chk_i (
    .clk(clk), .rst(rst), .hsync(hsync), .run(run), .lane_we(lane_we),
    .ctl_we(ctl_we), .wr_data(wr_data), .cnt_q(cnt_q), .ctl_q(ctl_q),
    .irq(irq)
);

// File: tb/scl_irq_timer_tb_top.sv
`timescale 1ns/1ps
module scl_irq_timer_tb_top;
    localparam logic [15:0] A_LO  = 16'hF000;
    localparam logic [15:0] A_HI  = 16'hF004;
    localparam logic [15:0] A_CTL = 16'hF008;
    localparam int          STEP  = 113;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        hsync = 1'b0;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    scl_irq_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input bit we, input logic [15:0] a,
                         input logic [7:0] d, input bit hs);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; hsync = hs;
        @(negedge clk);
        wr_en = 1'b0; hsync = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        drive(1'b1, a, d, 1'b0);
    endtask

    task automatic pulse();
        drive(1'b0, 16'h0000, 8'h00, 1'b1);
    endtask

    task automatic load(input int c, input logic [7:0] ctl);
        wr(A_CTL, 8'h00);
        wr(A_LO, c[7:0]);
        wr(A_HI, c[15:8]);
        wr(A_CTL, ctl);
    endtask

    // strobes until irq rises; 0 when it never does within the limit
    task automatic strobes_to_fire(input int limit, output int k);
        int i;
        k = 0;
        i = 0;
        while (k == 0 && i < limit) begin
            i++;
            pulse();
            if (irq) k = i;
        end
    endtask

    function automatic int expect_k(input int c);
        if (c <= STEP) return 1;
        return (c + STEP - 1) / STEP;
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 irq after reset", int'(irq), 0);

        // R6: run bit alone with count 0 and no strobes
        wr(A_CTL, 8'h02);
        repeat (10) @(negedge clk);
        check("R6 no strobe no irq", int'(irq), 0);

        // R1 R2 R3 R5: sweep of low counts, alternate ctl with extra bits
        for (int c = 0; c <= 700; c++) begin
            load(c, (c % 4 == 0) ? 8'hFF : 8'h02);
            strobes_to_fire(800, k);
            check("R5 strobes to fire (sweep)", k, expect_k(c));
        end
        // high byte sweep
        for (int h = 1; h < 256; h += 17) begin
            int c = h * 256 + 16'h35;
            load(c, 8'h02);
            strobes_to_fire(800, k);
            check("R2 high byte strobes", k, expect_k(c));
        end

        // R1: rewrite low byte keeps high byte
        load(16'h0290, 8'h00);
        wr(A_LO, 8'h07);
        wr(A_CTL, 8'h02);
        strobes_to_fire(800, k);
        check("R1 low rewrite keeps high", k, expect_k(16'h0207));

        // R3: run bit clear with other bits set: no counting
        load(0, 8'hFD);
        repeat (4) pulse();
        check("R3 bit1 clear no irq", int'(irq), 0);
        load(300, 8'h00);
        repeat (5) pulse();
        wr(A_CTL, 8'h02);
        strobes_to_fire(800, k);
        check("R3 count held while stopped", k, expect_k(300));

        // R7: hold, count writes do not clear, re-raise at zero
        load(5, 8'h02);
        pulse();
        repeat (3) pulse();
        check("R7 irq held over strobes", int'(irq), 1);
        wr(A_LO, 8'h55);
        check("R7 count write keeps irq", int'(irq), 1);
        wr(A_LO, 8'h00);
        wr(A_CTL, 8'h02);
        check("R4 ctl write clears irq", int'(irq), 0);
        pulse();
        check("R7 re-raise at zero", int'(irq), 1);

        // R10: other addresses ignored
        wr(16'hF009, 8'h00);
        wr(16'hF00C, 8'h00);
        check("R10 stray write keeps irq", int'(irq), 1);
        load(0, 8'h02);
        wr(16'hF005, 8'hFF);
        wr(16'hF001, 8'hFF);
        wr(16'h7000, 8'h00);
        strobes_to_fire(800, k);
        check("R10 stray write keeps count", k, 1);

        // R8: reset clears count and control
        load(16'hFFFF, 8'h02);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        repeat (3) pulse();
        check("R8 control cleared", int'(irq), 0);
        wr(A_CTL, 8'h02);
        strobes_to_fire(800, k);
        check("R8 count cleared", k, 1);

        // R9: low write with strobe: 256-113=0x8F, low<=5 -> 5
        load(256, 8'h02);
        drive(1'b1, A_LO, 8'h05, 1'b1);
        strobes_to_fire(800, k);
        check("R9 low write beats strobe", k, 1);
        // high write with strobe: 300-113=0xBB, high<=0 -> 187
        load(300, 8'h02);
        drive(1'b1, A_HI, 8'h00, 1'b1);
        strobes_to_fire(800, k);
        check("R9 high write beats strobe", k, expect_k(187));
        // control write with strobe uses old control byte
        load(200, 8'h00);
        drive(1'b1, A_CTL, 8'h02, 1'b1);
        strobes_to_fire(800, k);
        check("R9 strobe uses old control", k, expect_k(200));
        // control write with firing strobe leaves irq low
        load(0, 8'h02);
        drive(1'b1, A_CTL, 8'h02, 1'b1);
        check("R9 ctl write beats fire", int'(irq), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule